// File: doc/BRIEF.md
# System Control Register Bank

This block is a small coprocessor register bank that a processor core reaches with register-transfer operations. The core has one read port and one write port. Each port takes a 4-bit register index and, for writes, a 32-bit data word. Only the low three bits of the index select a register, so there are eight 32-bit slots. A separate debug port reaches the same slots with an index that is not masked. On that port, any index of 8 or above is dropped.

Slot 0 always reads back a fixed identification word, whatever was last stored there. Slot 1 is the control word. Four of its bits drive the mode outputs to the core:
- 32-bit program space
- 32-bit data space
- late-abort timing
- big-endian ordering

On reset, slot 1 is loaded from four strap pins. Every other bit and every other slot resets to zero. Each transfer completes in one cycle: a done pulse follows on the next cycle, and the block never stalls.

Top module: `scc_regbank`

## Requirements
- R1: While `rst` is high at a clock edge, slot 1 becomes the strap levels in bits 4 (program32), 5 (data32), 6 (late abort) and 7 (big endian), with all other bits zero. Slots 0 and 2..7 become zero, and the four mode outputs equal the straps on the following cycle.
- R2: The core read and write ports use only bits 2:0 of their 4-bit index, so index 9 reaches slot 1 and index 10 reaches slot 2.
- R3: A read of slot 0 returns 32'h41440110 on both the core and the debug port, even after slot 0 has been written.
- R4: A write to slot 1 updates the mode outputs at the same clock edge that accepts the write: `cfg_prog32` from bit 4, `cfg_data32` from bit 5, `cfg_late_abort` from bit 6 and `cfg_big_endian` from bit 7.
- R5: `cp_rd_done` and `cp_wr_done` are high in exactly the cycle after the matching enable was sampled. `cp_rd_data` is valid in that cycle, and results come back in request order.
- R6: On the debug port, an index of 8 to 15 is ignored. A write changes no slot and no mode output. A read leaves `dbg_rvalid` low and `dbg_rdata` unchanged.
- R7: A debug write with an index below 8 stores the word, and a debug write to slot 1 updates the mode outputs. A debug read below 8 raises `dbg_rvalid` and returns the slot one cycle later.
- R8: When the core and the debug port write the same slot in the same cycle, the core value is kept. Writes to different slots in the same cycle both take effect.
- R9: A read in the same cycle as a write to the same slot returns the value held before that write.
- R10: Slots 2..7 each store and return full 32-bit words independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_prog32 | input | 1 | Reset level of the program32 control bit |
| strap_data32 | input | 1 | Reset level of the data32 control bit |
| strap_late_abort | input | 1 | Reset level of the late-abort control bit |
| strap_big_endian | input | 1 | Reset level of the big-endian control bit |
| cp_rd_en | input | 1 | Core read request |
| cp_rd_idx | input | 4 | Core read index (low 3 bits used) |
| cp_rd_data | output | 32 | Core read result |
| cp_rd_done | output | 1 | Core read complete |
| cp_wr_en | input | 1 | Core write request |
| cp_wr_idx | input | 4 | Core write index (low 3 bits used) |
| cp_wr_data | input | 32 | Core write word |
| cp_wr_done | output | 1 | Core write complete |
| dbg_rd_en | input | 1 | Debug read request |
| dbg_wr_en | input | 1 | Debug write request |
| dbg_idx | input | 4 | Debug index (8..15 ignored) |
| dbg_wdata | input | 32 | Debug write word |
| dbg_rdata | output | 32 | Debug read result |
| dbg_rvalid | output | 1 | Debug read result valid |
| cfg_prog32 | output | 1 | Program32 mode |
| cfg_data32 | output | 1 | Data32 mode |
| cfg_late_abort | output | 1 | Late-abort timing mode |
| cfg_big_endian | output | 1 | Big-endian mode |

## Verification
The hardest situations to reach are the ones where two accesses meet in one cycle. These are a core and a debug write aimed at the control slot together, and a read that samples a slot while it is being overwritten. The stimulus task drives every port field in a single call, so both cases are issued on one clock edge. The expected read results are pushed before the model applies the write. The out-of-range debug index 12 is also chosen so that masking it would hit slot 4. A bank that wrongly wrapped debug indices would therefore corrupt a slot the bench reads back afterwards.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS);
  localparam int unsigned ID_SLOT   = 0;
  localparam int unsigned CTRL_SLOT = 1;
  // control bits 4..7 in order: program32, data32, late abort, big endian
  localparam int unsigned MODE_LSB = 4;
  localparam int unsigned MODE_W   = 4;
  localparam logic [DATA_W-1:0] ID_WORD = 32'h4144_0110;
endpackage

// File: rtl/scc_regfile.sv
module scc_regfile
  import scc_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NR = NUM_REGS,
  localparam int unsigned AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MODE_W-1:0] strap,
  // port A: core writes, wins on a same-slot collision
  input  logic          a_we,
  input  logic [AW-1:0] a_sel,
  input  logic [DW-1:0] a_wd,
  // port B: debug writes
  input  logic          b_we,
  input  logic [AW-1:0] b_sel,
  input  logic [DW-1:0] b_wd,
  input  logic [AW-1:0] ra_sel,
  output logic [DW-1:0] ra_q,
  input  logic [AW-1:0] rb_sel,
  output logic [DW-1:0] rb_q,
  output logic [MODE_W-1:0] mode
);
  logic [DW-1:0] mem [NR];
  logic [DW-1:0] seed;

  assign seed = DW'(strap) << MODE_LSB;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NR); i++)
        mem[i] <= (i == int'(CTRL_SLOT)) ? seed : '0;
    end else begin
      if (b_we) mem[b_sel] <= b_wd;
      if (a_we) mem[a_sel] <= a_wd;
    end
  end

  assign ra_q = mem[ra_sel];
  assign rb_q = mem[rb_sel];
  assign mode = mem[CTRL_SLOT][MODE_LSB +: MODE_W];
endmodule

// File: rtl/scc_rdport.sv
module scc_rdport
  import scc_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] sel,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] q,
  output logic          vld
);
  logic [DW-1:0] nxt;

  always_comb begin
    if (sel == AW'(ID_SLOT)) nxt = DW'(ID_WORD);
    else                     nxt = word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      vld <= en;
      if (en) q <= nxt;
    end
  end
endmodule

// File: rtl/scc_regbank.sv
module scc_regbank
  import scc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_prog32,
  input  logic              strap_data32,
  input  logic              strap_late_abort,
  input  logic              strap_big_endian,
  input  logic              cp_rd_en,
  input  logic [IDX_W-1:0]  cp_rd_idx,
  output logic [DATA_W-1:0] cp_rd_data,
  output logic              cp_rd_done,
  input  logic              cp_wr_en,
  input  logic [IDX_W-1:0]  cp_wr_idx,
  input  logic [DATA_W-1:0] cp_wr_data,
  output logic              cp_wr_done,
  input  logic              dbg_rd_en,
  input  logic              dbg_wr_en,
  input  logic [IDX_W-1:0]  dbg_idx,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              dbg_rvalid,
  output logic              cfg_prog32,
  output logic              cfg_data32,
  output logic              cfg_late_abort,
  output logic              cfg_big_endian
);
  logic [SEL_W-1:0]  rd_sel, wr_sel, dbg_sel;
  logic              dbg_in_range;
  logic [DATA_W-1:0] core_word, dbg_word;
  logic [MODE_W-1:0] mode;
  logic [2*(IDX_W-SEL_W)-1:0] unused_idx_hi;

  assign rd_sel        = cp_rd_idx[SEL_W-1:0];
  assign wr_sel        = cp_wr_idx[SEL_W-1:0];
  assign unused_idx_hi = {cp_rd_idx[IDX_W-1:SEL_W], cp_wr_idx[IDX_W-1:SEL_W]};
  assign dbg_sel       = dbg_idx[SEL_W-1:0];
  assign dbg_in_range  = (32'(dbg_idx) < NUM_REGS);

  scc_regfile #(.DW(DATA_W), .NR(NUM_REGS)) u_file (
    .clk    (clk),
    .rst    (rst),
    .strap  ({strap_big_endian, strap_late_abort, strap_data32, strap_prog32}),
    .a_we   (cp_wr_en),
    .a_sel  (wr_sel),
    .a_wd   (cp_wr_data),
    .b_we   (dbg_wr_en && dbg_in_range),
    .b_sel  (dbg_sel),
    .b_wd   (dbg_wdata),
    .ra_sel (rd_sel),
    .ra_q   (core_word),
    .rb_sel (dbg_sel),
    .rb_q   (dbg_word),
    .mode   (mode)
  );

  scc_rdport #(.DW(DATA_W), .AW(SEL_W)) u_core_rd (
    .clk  (clk),
    .rst  (rst),
    .en   (cp_rd_en),
    .sel  (rd_sel),
    .word (core_word),
    .q    (cp_rd_data),
    .vld  (cp_rd_done)
  );

  scc_rdport #(.DW(DATA_W), .AW(SEL_W)) u_dbg_rd (
    .clk  (clk),
    .rst  (rst),
    .en   (dbg_rd_en && dbg_in_range),
    .sel  (dbg_sel),
    .word (dbg_word),
    .q    (dbg_rdata),
    .vld  (dbg_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) cp_wr_done <= 1'b0;
    else     cp_wr_done <= cp_wr_en;
  end

  assign {cfg_big_endian, cfg_late_abort, cfg_data32, cfg_prog32} = mode;
endmodule

// File: rtl/scc_regbank_chk.sv
module scc_regbank_chk
  import scc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              strap_prog32,
  input logic              strap_data32,
  input logic              strap_late_abort,
  input logic              strap_big_endian,
  input logic              cp_rd_en,
  input logic [IDX_W-1:0]  cp_rd_idx,
  input logic [DATA_W-1:0] cp_rd_data,
  input logic              cp_rd_done,
  input logic              cp_wr_en,
  input logic [IDX_W-1:0]  cp_wr_idx,
  input logic [DATA_W-1:0] cp_wr_data,
  input logic              cp_wr_done,
  input logic              dbg_rd_en,
  input logic              dbg_wr_en,
  input logic [IDX_W-1:0]  dbg_idx,
  input logic [DATA_W-1:0] dbg_rdata,
  input logic              dbg_rvalid,
  input logic              cfg_prog32,
  input logic              cfg_data32,
  input logic              cfg_late_abort,
  input logic              cfg_big_endian
);
  logic [3:0] mode_o, strap_i;
  assign mode_o  = {cfg_big_endian, cfg_late_abort, cfg_data32, cfg_prog32};
  assign strap_i = {strap_big_endian, strap_late_abort, strap_data32, strap_prog32};

  // R1
  reset_seed_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mode_o == $past(strap_i));
  // R3
  id_word_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_rd_en && cp_rd_idx[2:0] == 3'd0) |=> cp_rd_data == ID_WORD);
  // R4
  mode_update_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_wr_en && cp_wr_idx[2:0] == 3'd1) |=> mode_o == $past(cp_wr_data[7:4]));
  // R5
  rd_done_chk: assert property (@(posedge clk) disable iff (rst)
    cp_rd_en |=> cp_rd_done);
  // R5
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cp_rd_en |=> !cp_rd_done);
  // R5
  wr_done_chk: assert property (@(posedge clk) disable iff (rst)
    cp_wr_en |=> cp_wr_done);
  // R6
  dbg_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_rd_en && dbg_idx[3]) |=> (!dbg_rvalid && $stable(dbg_rdata)));
  // R6
  dbg_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_wr_en && dbg_idx[3] && !(cp_wr_en && cp_wr_idx[2:0] == 3'd1)) |=> $stable(mode_o));
endmodule

bind scc_regbank scc_regbank_chk u_chk (.*);

// File: tb/sim_scc_regbank.sv
module sim_scc_regbank;
  logic clk = 1'b0, rst = 1'b1;
  logic sp = 1'b1, sd = 1'b0, sl = 1'b1, sb = 1'b0;
  logic cre = 0, cwe = 0, dre = 0, dwe = 0;
  logic [3:0] cri = 0, cwi = 0, di = 0;
  logic [31:0] cwd = 0, dwd = 0;
  logic [31:0] crd, drd;
  logic crdone, cwdone, drv, cp32, cd32, cla, cbe;
  int errs = 0, checks = 0;
  logic [31:0] mdl [8];
  logic [31:0] expq [$];
  string tagq [$];
  localparam logic [31:0] ID = 32'h4144_0110;

  always #4 clk = ~clk;

  scc_regbank u0 (
    .clk(clk), .rst(rst), .strap_prog32(sp), .strap_data32(sd),
    .strap_late_abort(sl), .strap_big_endian(sb),
    .cp_rd_en(cre), .cp_rd_idx(cri), .cp_rd_data(crd), .cp_rd_done(crdone),
    .cp_wr_en(cwe), .cp_wr_idx(cwi), .cp_wr_data(cwd), .cp_wr_done(cwdone),
    .dbg_rd_en(dre), .dbg_wr_en(dwe), .dbg_idx(di), .dbg_wdata(dwd),
    .dbg_rdata(drd), .dbg_rvalid(drv),
    .cfg_prog32(cp32), .cfg_data32(cd32), .cfg_late_abort(cla), .cfg_big_endian(cbe));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rdval(input logic [2:0] s);
    return (s == 3'd0) ? ID : mdl[s];
  endfunction

  // monitor: pops one expectation for every core read completion
  always @(negedge clk) begin
    if (!rst && crdone) begin
      if (expq.size() == 0) chk(0, "R5 unexpected done", 32'd1, 32'd0);
      else begin
        string t;
        logic [31:0] e;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(crd === e, t, crd, e);
      end
    end
  end

  // one cycle on all ports; expectations pushed before the model takes writes (R9)
  task automatic op(input bit r, input logic [3:0] ri, input bit w, input logic [3:0] wi,
                    input logic [31:0] wd, input bit dr, input bit dw, input logic [3:0] dx,
                    input logic [31:0] dd, input string tag);
    cre = r; cri = ri; cwe = w; cwi = wi; cwd = wd;
    dre = dr; dwe = dw; di = dx; dwd = dd;
    if (r) begin expq.push_back(rdval(ri[2:0])); tagq.push_back(tag); end
    if (dw && dx < 4'd8) mdl[dx[2:0]] = dd;
    if (w) mdl[wi[2:0]] = wd;
    @(negedge clk);
    cre = 0; cwe = 0; dre = 0; dwe = 0;
  endtask

  task automatic rd(input logic [3:0] i, input string tag);
    op(1, i, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input logic [3:0] i, input logic [31:0] d, input string tag);
    op(0, 0, 1, i, d, 0, 0, 0, 0, tag);
    chk(cwdone === 1'b1, {tag, " R5 wr_done"}, 32'(cwdone), 32'd1);
  endtask
  task automatic mode_is(input logic [3:0] e, input string tag);
    chk({cbe, cla, cd32, cp32} === e, tag, 32'({cbe, cla, cd32, cp32}), 32'(e));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 32'd0;
    mdl[1] = 32'h0000_0050;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    mode_is(4'b0101, "R1 straps");
    chk(crdone === 1'b0 && cwdone === 1'b0, "R5 idle done", 32'(crdone), 32'd0);
    rd(1, "R1 slot1 seed"); rd(5, "R1 slot5 zero");
    wr(1, 32'hFFFF_FF3F, "R4"); mode_is(4'b0011, "R4 mode");
    wr(9, 32'h0000_00A0, "R2"); mode_is(4'b1010, "R2 alias mode");
    rd(1, "R2 slot1");
    wr(10, 32'h1234_5678, "R2"); rd(2, "R2 idx10"); rd(10, "R2 rd alias");
    wr(0, 32'hDEAD_BEEF, "R3"); rd(0, "R3 id"); rd(8, "R3 id alias");
    op(0, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
    chk(drv === 1'b1 && drd === ID, "R3 dbg id", drd, ID);
    for (int i = 2; i < 8; i++) wr(4'(i), (32'h1111_1111 * i) ^ 32'hA5A5_A5A5, "R10");
    for (int i = 7; i >= 2; i--) rd(4'(i), "R10 readback");
    op(1, 3, 1, 3, 32'hCAFE_0003, 0, 0, 0, 0, "R9 old value");
    rd(3, "R9 new value");
    op(0, 0, 0, 0, 0, 0, 1, 12, 32'hFFFF_FFFF, "R6");
    rd(4, "R6 slot4 kept"); mode_is(4'b1010, "R6 mode kept");
    op(0, 0, 0, 0, 0, 1, 0, 9, 0, "R6");
    chk(drv === 1'b0 && drd === ID, "R6 dbg read ignored", drd, ID);
    op(0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_0010, "R7"); mode_is(4'b0001, "R7 mode");
    op(0, 0, 0, 0, 0, 1, 0, 1, 0, "R7");
    chk(drv === 1'b1 && drd === 32'h10, "R7 dbg read", drd, 32'h10);
    op(0, 0, 1, 1, 32'h0000_0080, 0, 1, 1, 32'h0000_0040, "R8");
    mode_is(4'b1000, "R8 core wins"); rd(1, "R8 slot1");
    op(0, 0, 1, 5, 32'h5555_0005, 0, 1, 6, 32'h6666_0006, "R8");
    rd(5, "R8 both a"); rd(6, "R8 both b");
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
    chk(crdone === 1'b0, "R5 done drops", 32'(crdone), 32'd0);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R5 all reads returned", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule